// File: doc/BRIEF.md
# Multi-Channel Block Transfer Engine

This block moves words between peripherals and a memory bus on behalf of a processor, so that the processor is not involved in each word. Each channel has its own set of registers for a memory address, a byte count and a control word. Software fills in one or more channels and sets their enable bits. Each peripheral then raises its request line whenever it can accept or supply a word. The engine picks one requesting channel, asks for the system bus with a request/grant pair, and moves words while the grant is held. It updates that channel's address and count after every word.

A channel runs in one of two bus-use modes. In cycle-stealing mode it moves a single word for each grant and then hands the bus back. In burst mode it keeps the bus for a run of words, and a per-channel field sets the longest run. A global configuration bit chooses how the next channel is picked: by fixed priority, or by a rotating priority in which the channel just chosen drops to the bottom. When a channel's count reaches zero, the engine sets that channel's completion flag and clears its enable bit. An interrupt line is raised for every completion flag whose interrupt enable is set.

Top module: `dmac_multi`

## Requirements
- R1: After reset every register reads zero, and `bus_req`, `irq`, `mem_we`, `mem_re` and `dev_ack` are low.
- R2: The register address is {global, channel[1:0], slot[1:0]}. With global=0, slot 0 is the memory address, slot 1 the byte count, slot 2 the control byte (bit0 enable, bit1 direction with 1 meaning memory-to-device, bit2 burst, bit3 interrupt enable, bits 7:4 maximum burst) and slot 3 the status (bit0 done). With global=1, bit0 selects round-robin arbitration. Register bits that are not implemented read zero.
- R3: `mem_we` or `mem_re` is asserted only while `bus_gnt` and `bus_req` are both high. While the grant is withheld, `bus_req` stays high and no word moves.
- R4: In cycle-stealing mode (control bit2=0), a channel moves exactly one word per grant, and `bus_req` is low in the following cycle.
- R5: In burst mode, a channel moves words on consecutive granted cycles until the maximum burst is reached (0 means 16 words), the count runs out, or the peripheral withdraws its request. `bus_req` then falls.
- R6: Each word adds 4 to the channel's address and subtracts 4 from its byte count, saturating at zero. With direction 0 the device word is written to memory (`mem_we`, `mem_wdata`=`dev_rdata`). With direction 1 memory is read (`mem_re`, `dev_wdata`=`mem_rdata`). `mem_addr` carries the address held before the increment.
- R7: When the byte count reaches zero, the done bit is set and the enable bit is cleared. Writing 1 to status bit0 clears done, and writing 0 leaves it unchanged.
- R8: `irq` is high exactly when some channel has both done and interrupt enable set.
- R9: With the global bit at 0, the lowest-numbered eligible channel (enabled, nonzero count, request high) wins.
- R10: With the global bit at 1, the search starts at the channel after the one chosen last, so the last chosen channel has the lowest priority.
- R11: A word moves only while the active channel's `dev_req` is high, and `dev_ack` pulses one-hot for that channel on each moved word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from `reg_addr`) |
| dev_req | input | 4 | Per-channel peripheral request |
| dev_ack | output | 4 | Per-channel word-moved pulse |
| dev_rdata | input | 32 | Word from the peripheral |
| dev_wdata | output | 32 | Word to the peripheral |
| bus_req | output | 1 | System bus request |
| bus_gnt | input | 1 | System bus grant |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data (same cycle) |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| irq | output | 1 | Completion interrupt |

## Verification
A register write lands at the clock edge that samples it, and its readback, along with `irq`, is visible from the next falling edge. A channel that becomes eligible raises `bus_req` one edge later. The first word moves in the cycle after the edge that sees the grant, and `bus_req` falls one edge after the final word. The bench's reference model advances at each rising edge from the same sampled inputs as the design. Every output is compared against that model at the following falling edge, so each result is checked in the cycle where it is due. Explicit checks on top of this look at the service order, the run lengths per grant and the register contents once each scenario has settled.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
   localparam int unsigned MAXB_W = 4;

   typedef struct packed {
      logic [MAXB_W-1:0] maxb;
      logic              ie;
      logic              burst;
      logic              dir;
      logic              en;
   } ctl_t;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_WAIT,
      ST_MOVE
   } seq_st_t;

   localparam logic [1:0] SLOT_ADDR = 2'd0;
   localparam logic [1:0] SLOT_CNT  = 2'd1;
   localparam logic [1:0] SLOT_CTL  = 2'd2;
   localparam logic [1:0] SLOT_STAT = 2'd3;
endpackage

// File: rtl/dmac_regs.sv
module dmac_regs
   import dmac_pkg::*;
#(
   parameter int unsigned NCH = 4,
   parameter int unsigned AW  = 16,
   parameter int unsigned CW  = 16,
   parameter int unsigned RW  = 32,
   parameter int unsigned WB  = 4,
   parameter bit          ARB_RR_INIT = 1'b0,
   localparam int unsigned CHB = $clog2(NCH),
   localparam int unsigned RAW = CHB + 3
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     reg_we,
   input  logic [RAW-1:0]           reg_addr,
   input  logic [RW-1:0]            reg_wdata,
   output logic [RW-1:0]            reg_rdata,
   input  logic                     mv,
   input  logic [CHB-1:0]           mv_ch,
   output logic [NCH-1:0][AW-1:0]   addr_q,
   output logic [NCH-1:0][CW-1:0]   cnt_q,
   output ctl_t [NCH-1:0]           ctl_q,
   output logic [NCH-1:0]           done_q,
   output logic                     arb_rr
);
   localparam logic [CW-1:0] STEP_C = CW'(WB);
   localparam logic [AW-1:0] STEP_A = AW'(WB);

   logic           glob;
   logic [1:0]     slot;
   logic [CHB-1:0] rch;

   assign glob = reg_addr[RAW-1];
   assign slot = reg_addr[1:0];
   assign rch  = reg_addr[RAW-2:2];

   always_ff @(posedge clk) begin
      if (!rst_n)                arb_rr <= ARB_RR_INIT;
      else if (reg_we && glob)   arb_rr <= reg_wdata[0];
   end

   for (genvar i = 0; i < NCH; i++) begin : g_ch
      logic hit;
      logic fin;
      assign hit = reg_we && !glob && (rch == CHB'(i));
      assign fin = cnt_q[i] <= STEP_C;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            addr_q[i] <= '0;
            cnt_q[i]  <= '0;
            ctl_q[i]  <= '0;
            done_q[i] <= 1'b0;
         end else begin
            if (mv && (mv_ch == CHB'(i))) begin
               addr_q[i] <= addr_q[i] + STEP_A;
               cnt_q[i]  <= fin ? '0 : cnt_q[i] - STEP_C;
               if (fin) begin
                  done_q[i]   <= 1'b1;
                  ctl_q[i].en <= 1'b0;
               end
            end
            if (hit) begin
               case (slot)
                  SLOT_ADDR: addr_q[i] <= reg_wdata[AW-1:0];
                  SLOT_CNT:  cnt_q[i]  <= reg_wdata[CW-1:0];
                  SLOT_CTL:  ctl_q[i]  <= ctl_t'(reg_wdata[$bits(ctl_t)-1:0]);
                  default:   if (reg_wdata[0]) done_q[i] <= 1'b0;
               endcase
            end
         end
      end
   end

   always_comb begin
      reg_rdata = '0;
      if (glob) begin
         reg_rdata[0] = arb_rr;
      end else begin
         case (slot)
            SLOT_ADDR: reg_rdata[AW-1:0]           = addr_q[rch];
            SLOT_CNT:  reg_rdata[CW-1:0]           = cnt_q[rch];
            SLOT_CTL:  reg_rdata[$bits(ctl_t)-1:0] = ctl_q[rch];
            default:   reg_rdata[0]                = done_q[rch];
         endcase
      end
   end
endmodule

// File: rtl/dmac_arb.sv
module dmac_arb #(
   parameter int unsigned NCH = 4,
   localparam int unsigned CHB = $clog2(NCH)
) (
   input  logic [NCH-1:0] elig,
   input  logic           rr_mode,
   input  logic [CHB-1:0] last,
   output logic           any,
   output logic [CHB-1:0] win
);
   logic [CHB-1:0] win_fix;
   logic [CHB-1:0] win_rr;

   always_comb begin
      win_fix = '0;
      for (int i = NCH - 1; i >= 0; i--) begin
         if (elig[i]) win_fix = CHB'(i);
      end
   end

   always_comb begin
      win_rr = '0;
      for (int k = NCH; k >= 1; k--) begin
         if (elig[last + CHB'(k)]) win_rr = last + CHB'(k);
      end
   end

   assign any = |elig;
   assign win = rr_mode ? win_rr : win_fix;
endmodule

// File: rtl/dmac_seq.sv
module dmac_seq
   import dmac_pkg::*;
#(
   parameter int unsigned NCH = 4,
   localparam int unsigned CHB = $clog2(NCH),
   localparam int unsigned BTW = MAXB_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              any,
   input  logic [CHB-1:0]    win,
   input  logic              bus_gnt,
   input  logic [NCH-1:0]    dev_req,
   input  logic              burst_cur,
   input  logic [MAXB_W-1:0] maxb_cur,
   input  logic              lastword,
   output logic              bus_req,
   output logic              mv,
   output logic [CHB-1:0]    cur
);
   seq_st_t        st;
   logic [BTW-1:0] beats;
   logic [BTW-1:0] lim;

   assign lim     = (maxb_cur == '0) ? BTW'(1 << MAXB_W) : BTW'(maxb_cur);
   assign bus_req = (st != ST_IDLE);
   assign mv      = (st == ST_MOVE) && bus_gnt && dev_req[cur];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st    <= ST_IDLE;
         cur   <= CHB'(NCH - 1);
         beats <= '0;
      end else begin
         case (st)
            ST_IDLE: if (any) begin
               cur   <= win;
               beats <= '0;
               st    <= ST_WAIT;
            end
            ST_WAIT: if (bus_gnt) st <= ST_MOVE;
            default: begin
               if (!mv) begin
                  st <= ST_IDLE;
               end else begin
                  beats <= beats + 1'b1;
                  if (lastword || !burst_cur || (beats + 1'b1 == lim)) st <= ST_IDLE;
               end
            end
         endcase
      end
   end
endmodule

// File: rtl/dmac_multi.sv
module dmac_multi
   import dmac_pkg::*;
#(
   parameter int unsigned NCH = 4,
   parameter int unsigned AW  = 16,
   parameter int unsigned CW  = 16,
   parameter int unsigned DW  = 32,
   parameter int unsigned RW  = 32,
   parameter bit          ARB_RR_INIT = 1'b0,
   localparam int unsigned CHB = $clog2(NCH),
   localparam int unsigned RAW = CHB + 3,
   localparam int unsigned WB  = DW / 8
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           reg_we,
   input  logic [RAW-1:0] reg_addr,
   input  logic [RW-1:0]  reg_wdata,
   output logic [RW-1:0]  reg_rdata,
   input  logic [NCH-1:0] dev_req,
   output logic [NCH-1:0] dev_ack,
   input  logic [DW-1:0]  dev_rdata,
   output logic [DW-1:0]  dev_wdata,
   output logic           bus_req,
   input  logic           bus_gnt,
   output logic [AW-1:0]  mem_addr,
   output logic [DW-1:0]  mem_wdata,
   input  logic [DW-1:0]  mem_rdata,
   output logic           mem_we,
   output logic           mem_re,
   output logic           irq
);
   if (NCH < 2 || (NCH & (NCH - 1)) != 0) begin : g_bad_nch
      $error("NCH must be a power of two, at least 2");
   end
   if (DW % 8 != 0 || DW < 8) begin : g_bad_dw
      $error("DW must be a whole number of bytes");
   end
   if (AW > RW || CW > RW || RW < $bits(ctl_t)) begin : g_bad_rw
      $error("register width too narrow");
   end

   logic [NCH-1:0][AW-1:0] addr_q;
   logic [NCH-1:0][CW-1:0] cnt_q;
   ctl_t [NCH-1:0]         ctl_q;
   logic [NCH-1:0]         done_q;
   logic [NCH-1:0]         elig;
   logic [NCH-1:0]         ie_vec;
   logic                   arb_rr;
   logic                   any;
   logic [CHB-1:0]         win;
   logic [CHB-1:0]         cur;
   logic                   mv;
   logic                   lastword;
   logic                   burst_cur;

   dmac_regs #(
      .NCH(NCH), .AW(AW), .CW(CW), .RW(RW), .WB(WB), .ARB_RR_INIT(ARB_RR_INIT)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mv(mv), .mv_ch(cur),
      .addr_q(addr_q), .cnt_q(cnt_q), .ctl_q(ctl_q), .done_q(done_q), .arb_rr(arb_rr)
   );

   for (genvar i = 0; i < NCH; i++) begin : g_elig
      assign elig[i]   = ctl_q[i].en && (cnt_q[i] != '0) && dev_req[i];
      assign ie_vec[i] = ctl_q[i].ie;
   end

   dmac_arb #(.NCH(NCH)) u_arb (
      .elig(elig), .rr_mode(arb_rr), .last(cur), .any(any), .win(win)
   );

   assign lastword  = cnt_q[cur] <= CW'(WB);
   assign burst_cur = ctl_q[cur].burst;

   dmac_seq #(.NCH(NCH)) u_seq (
      .clk(clk), .rst_n(rst_n), .any(any), .win(win), .bus_gnt(bus_gnt),
      .dev_req(dev_req), .burst_cur(burst_cur), .maxb_cur(ctl_q[cur].maxb),
      .lastword(lastword), .bus_req(bus_req), .mv(mv), .cur(cur)
   );

   assign mem_addr  = addr_q[cur];
   assign mem_we    = mv && !ctl_q[cur].dir;
   assign mem_re    = mv && ctl_q[cur].dir;
   assign mem_wdata = dev_rdata;
   assign dev_wdata = mem_rdata;
   assign dev_ack   = mv ? (NCH'(1) << cur) : '0;
   assign irq       = |(done_q & ie_vec);
endmodule

// File: rtl/dmac_multi_chk.sv
module dmac_multi_chk #(
   parameter int unsigned NCH = 4,
   parameter int unsigned AW  = 16,
   parameter int unsigned WB  = 4,
   localparam int unsigned CHB = $clog2(NCH)
) (
   input logic           clk,
   input logic           rst_n,
   input logic           bus_req,
   input logic           bus_gnt,
   input logic           mem_we,
   input logic           mem_re,
   input logic [AW-1:0]  mem_addr,
   input logic [NCH-1:0] dev_req,
   input logic [NCH-1:0] dev_ack,
   input logic           reg_we,
   input logic           mv,
   input logic           lastword,
   input logic           burst_cur,
   input logic [CHB-1:0] cur,
   input logic [NCH-1:0] done_q
);
   p_owned_bus_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we || mem_re) |-> (bus_gnt && bus_req));

   p_single_word_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (mv && !burst_cur) |=> !bus_req);

   p_addr_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (mv && !reg_we) |=> (mem_addr == $past(mem_addr) + AW'(WB)));

   p_one_dir_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_we && mem_re));

   p_done_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (mv && lastword && !reg_we) |=> done_q[$past(cur)]);

   p_ack_onehot_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(dev_ack));

   p_ack_req_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (dev_ack != '0) |-> ((dev_ack & dev_req) != '0));
endmodule

bind dmac_multi dmac_multi_chk #(.NCH(NCH), .AW(AW), .WB(WB)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_gnt(bus_gnt),
   .mem_we(mem_we), .mem_re(mem_re), .mem_addr(mem_addr), .dev_req(dev_req),
   .dev_ack(dev_ack), .reg_we(reg_we), .mv(mv), .lastword(lastword),
   .burst_cur(burst_cur), .cur(cur), .done_q(done_q)
);

// File: tb/dmac_multi_tb.sv
module dmac_multi_tb;
   localparam int CLK_PERIOD = 10;
   localparam int NCH = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [4:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [3:0]  dev_req = '0;
   logic [3:0]  dev_ack;
   logic [31:0] dev_rdata = 32'hC0DE_0000;
   logic [31:0] dev_wdata;
   logic        bus_req;
   logic        bus_gnt = 1'b0;
   logic [15:0] mem_addr;
   logic [31:0] mem_wdata;
   logic [31:0] mem_rdata;
   logic        mem_we;
   logic        mem_re;
   logic        irq;

   int  n_chk = 0;
   int  n_bad = 0;
   bit  gnt_allow = 1'b1;
   int  cyc = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dmac_multi u_dut (.*);

   assign mem_rdata = {16'h5A00, mem_addr};

   // reference model state
   int unsigned m_addr [NCH];
   int unsigned m_cnt  [NCH];
   bit [7:0]    m_ctl  [NCH];
   bit          m_done [NCH];
   bit          m_rr;
   int          m_ph, m_cur, m_beats;

   // monitors
   int run_len = 0, max_run = 0, strobes = 0;
   int order[$];

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h (t=%0t)", tag, act, exp, $time);
      end
   endtask

   function automatic bit m_elig(int c);
      return m_ctl[c][0] && m_cnt[c] != 0 && dev_req[c];
   endfunction

   function automatic bit m_move();
      return m_ph == 2 && bus_gnt && dev_req[m_cur];
   endfunction

   function automatic bit m_irq();
      bit r = 0;
      for (int c = 0; c < NCH; c++) r |= m_done[c] & m_ctl[c][3];
      return r;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int c = 0; c < NCH; c++) begin
            m_addr[c] = 0; m_cnt[c] = 0; m_ctl[c] = 0; m_done[c] = 0;
         end
         m_rr = 0; m_ph = 0; m_cur = NCH - 1; m_beats = 0;
      end else begin
         automatic bit mv = m_move();
         automatic int win = -1;
         automatic int lim;
         automatic bit fin;
         cyc++;
         case (m_ph)
            0: begin
               if (m_rr) begin
                  for (int k = 1; k <= NCH; k++)
                     if (win < 0 && m_elig((m_cur + k) % NCH)) win = (m_cur + k) % NCH;
               end else begin
                  for (int c = 0; c < NCH; c++) if (win < 0 && m_elig(c)) win = c;
               end
               if (win >= 0) begin m_cur = win; m_ph = 1; m_beats = 0; end
            end
            1: if (bus_gnt) m_ph = 2;
            default: begin
               if (!mv) m_ph = 0;
               else begin
                  lim = (m_ctl[m_cur][7:4] == 0) ? 16 : int'(m_ctl[m_cur][7:4]);
                  fin = m_cnt[m_cur] <= 4;
                  m_beats++;
                  m_addr[m_cur] = (m_addr[m_cur] + 4) & 32'hFFFF;
                  m_cnt[m_cur]  = fin ? 0 : m_cnt[m_cur] - 4;
                  if (fin) begin m_done[m_cur] = 1; m_ctl[m_cur][0] = 0; end
                  if (fin || !m_ctl[m_cur][2] || m_beats == lim) m_ph = 0;
               end
            end
         endcase
         if (reg_we) begin
            if (reg_addr[4]) m_rr = reg_wdata[0];
            else case (reg_addr[1:0])
               2'd0: m_addr[reg_addr[3:2]] = reg_wdata[15:0];
               2'd1: m_cnt[reg_addr[3:2]]  = reg_wdata[15:0];
               2'd2: m_ctl[reg_addr[3:2]]  = reg_wdata[7:0];
               default: if (reg_wdata[0]) m_done[reg_addr[3:2]] = 0;
            endcase
         end
      end
   end

   // grant follows request, gated by the bench
   always @(negedge clk) bus_gnt <= bus_req & gnt_allow;

   // per-cycle comparison against the model
   always @(negedge clk) begin
      #2;
      if (rst_n) begin
         automatic bit mv = m_move();
         automatic bit [3:0] ack_e = mv ? 4'(1 << m_cur) : 4'h0;
         chk(bus_req == (m_ph != 0), "R4/R5 bus_req", bus_req, m_ph != 0);
         chk(mem_we == (mv && !m_ctl[m_cur][1]), "R3 mem_we", mem_we, mv && !m_ctl[m_cur][1]);
         chk(mem_re == (mv && m_ctl[m_cur][1]), "R3 mem_re", mem_re, mv && m_ctl[m_cur][1]);
         chk(dev_ack == ack_e, "R11 dev_ack", dev_ack, ack_e);
         chk(irq == m_irq(), "R8 irq", irq, m_irq());
         if (mv) begin
            chk(mem_addr == m_addr[m_cur][15:0], "R6 mem_addr", mem_addr, m_addr[m_cur]);
            if (m_ctl[m_cur][1]) chk(dev_wdata == mem_rdata, "R6 dev_wdata", dev_wdata, mem_rdata);
            else                 chk(mem_wdata == dev_rdata, "R6 mem_wdata", mem_wdata, dev_rdata);
         end
         if (mem_we || mem_re) begin
            strobes++;
            run_len++;
            for (int c = 0; c < NCH; c++) if (dev_ack[c]) order.push_back(c);
         end else begin
            if (run_len > max_run) max_run = run_len;
            run_len = 0;
         end
         dev_rdata = 32'hC0DE_0000 | cyc;
      end
   end

   function automatic [4:0] ra(int ch, int slot);
      return {1'b0, 2'(ch), 2'(slot)};
   endfunction

   task automatic wr(input [4:0] a, input [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input [4:0] a, input [31:0] exp, input string tag);
      @(negedge clk);
      reg_addr = a;
      #1;
      chk(reg_rdata == exp, tag, reg_rdata, exp);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state
      for (int c = 0; c < NCH; c++)
         for (int s = 0; s < 4; s++) rd(ra(c, s), 32'h0, "R1 reset reg");
      rd(5'b10000, 32'h0, "R1 reset global");
      chk(!bus_req && !irq && !mem_we && !mem_re && dev_ack == 0, "R1 outputs", {bus_req, irq}, 0);

      // R2: readback and unimplemented bits
      wr(ra(0, 0), 32'hFFFF_0100);
      wr(ra(0, 1), 32'h0001_0010);
      wr(ra(0, 2), 32'hFFFF_FF3E);
      rd(ra(0, 0), 32'h0100, "R2 addr readback");
      rd(ra(0, 1), 32'h0010, "R2 count readback");
      rd(ra(0, 2), 32'h003E, "R2 ctl readback");
      wr(5'b10000, 32'hFFFF_FFFE);
      rd(5'b10000, 32'h0, "R2 global readback");

      // R4/R7/R8: cycle stealing, device to memory, 4 words
      max_run = 0;
      wr(ra(0, 2), 32'h09);
      dev_req = 4'b0001;
      repeat (40) @(negedge clk);
      chk(max_run == 1, "R4 words per grant", max_run, 1);
      rd(ra(0, 0), 32'h0110, "R6 final address");
      rd(ra(0, 1), 32'h0, "R6 final count");
      rd(ra(0, 2), 32'h08, "R7 enable cleared");
      rd(ra(0, 3), 32'h1, "R7 done set");
      chk(irq == 1'b1, "R8 irq raised", irq, 1);
      wr(ra(0, 3), 32'h0);
      rd(ra(0, 3), 32'h1, "R7 write zero keeps done");
      wr(ra(0, 3), 32'h1);
      rd(ra(0, 3), 32'h0, "R7 write one clears done");
      chk(irq == 1'b0, "R8 irq cleared", irq, 0);
      dev_req = 4'b0000;

      // R5/R6/R8: burst, memory to device, max 3, 8 words, no irq enable
      max_run = 0;
      wr(ra(1, 0), 32'h0200);
      wr(ra(1, 1), 32'h0020);
      wr(ra(1, 2), 32'h37);
      dev_req = 4'b0010;
      repeat (40) @(negedge clk);
      chk(max_run == 3, "R5 burst cap", max_run, 3);
      rd(ra(1, 0), 32'h0220, "R6 burst final address");
      rd(ra(1, 3), 32'h1, "R7 burst done");
      chk(irq == 1'b0, "R8 no irq without enable", irq, 0);
      wr(ra(1, 3), 32'h1);
      dev_req = 4'b0000;

      // R5: max burst field 0 means 16
      max_run = 0;
      wr(ra(0, 0), 32'h0300);
      wr(ra(0, 1), 32'h0040);
      wr(ra(0, 2), 32'h05);
      dev_req = 4'b0001;
      repeat (30) @(negedge clk);
      chk(max_run == 16, "R5 burst of 16", max_run, 16);
      dev_req = 4'b0000;
      wr(ra(0, 3), 32'h1);

      // R9: fixed priority
      for (int c = 1; c < 4; c++) begin
         wr(ra(c, 1), 32'h8);
         wr(ra(c, 2), 32'h01);
      end
      order.delete();
      dev_req = 4'b1110;
      repeat (40) @(negedge clk);
      chk(order.size() == 6, "R9 word total", order.size(), 6);
      foreach (order[i]) chk(order[i] == 1 + i / 2, "R9 fixed order", order[i], 1 + i / 2);
      dev_req = 4'b0000;

      // R10: round robin, last chosen was channel 3
      wr(5'b10000, 32'h1);
      for (int c = 1; c < 4; c++) begin
         wr(ra(c, 1), 32'h8);
         wr(ra(c, 2), 32'h01);
      end
      order.delete();
      dev_req = 4'b1110;
      repeat (40) @(negedge clk);
      chk(order.size() == 6, "R10 word total", order.size(), 6);
      foreach (order[i]) chk(order[i] == 1 + i % 3, "R10 rotating order", order[i], 1 + i % 3);
      dev_req = 4'b0000;

      // R3/R11: withheld grant, then request withdrawn mid-burst
      wr(ra(2, 0), 32'h0400);
      wr(ra(2, 1), 32'h0020);
      wr(ra(2, 2), 32'h0D);
      gnt_allow = 1'b0;
      dev_req = 4'b0100;
      strobes = 0;
      repeat (6) @(negedge clk);
      chk(strobes == 0, "R3 no word without grant", strobes, 0);
      chk(bus_req == 1'b1, "R3 request held", bus_req, 1);
      gnt_allow = 1'b1;
      repeat (4) @(negedge clk);
      dev_req = 4'b0000;
      strobes = 0;
      repeat (5) @(negedge clk);
      chk(strobes == 0, "R11 no word while request low", strobes, 0);
      dev_req = 4'b0100;
      repeat (20) @(negedge clk);
      rd(ra(2, 1), 32'h0, "R11 count drained");
      rd(ra(2, 0), 32'h0420, "R11 final address");
      chk(irq == 1'b1, "R8 irq on channel 2", irq, 1);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule